// File: doc/BRIEF.md
# 4B/5B Receive Symbol Decoder

This block sits on the 100 Mb/s receive path, after descrambling and code-group alignment. Each cycle of the 25 MHz receive clock it takes one aligned 5-bit code-group. It watches for the two-symbol start-of-stream delimiter (J then K), turns each data code-group inside a frame into a 4-bit nibble, and closes the frame on the two-symbol end-of-stream delimiter (T then R). It drives an MII-style receive interface of three signals: a data-valid flag, a data nibble and an error flag.

Errors are reported in two ways. If a J is not followed by a K, this is a malformed start delimiter. The block raises the error flag for one code-group time with the fixed nibble 1110, keeps data-valid low, and goes back to waiting for a J. Inside a frame, any code-group that is neither data nor a T raises the error flag with data-valid high, and the frame goes on. A T that is not followed by an R also raises the error flag, and the frame ends. Every output is registered, so each output reflects the code-group sampled at the previous rising edge.

Top module: `rx4b5b_rx`

## Requirements
- R1: A synchronous active-high reset clears the decoder state. On the edge after reset, data-valid, error and the nibble are all 0.
- R2: Outside a frame, every code-group other than J (11111 idle, 00000, 01101 and so on) leaves all three outputs low and raises no error.
- R3: A J (11000) followed by a K (10001) opens a frame. Neither delimiter symbol is shown as data: the outputs stay low for both. Data-valid first rises for the code-group after the K.
- R4: Inside a frame, the data code-groups 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100 and 11101 decode to the nibbles 0 to F in that order. Each is shown with data-valid 1 and error 0.
- R5: When a J is followed by anything other than a K, error goes to 1, the nibble is 1110 and data-valid stays 0, for exactly one code-group time. The decoder then waits for a new J, so a J in that second position is not the start of a new delimiter.
- R6: Inside a frame, a code-group that is neither data nor T (for example 00000, 11111, 11000) gives error 1 with data-valid 1, and the frame continues with the next data code-group.
- R7: A T (01101) inside a frame ends the data. All outputs are low for the T and for the R (00111) that follows it, and the decoder then waits for a J.
- R8: When a T inside a frame is followed by anything other than R, error is 1 with data-valid 0 for that one code-group time. The frame is then closed.
- R9: Every output changes exactly one clock edge after the code-group that causes the change is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 25 MHz receive clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| code_i | input | 5 | Aligned, descrambled code-group for this cycle |
| rx_dv | output | 1 | Receive data valid |
| rxd | output | 4 | Decoded receive nibble, or 1110 on a malformed start delimiter |
| rx_er | output | 1 | Receive error flag |

## Verification
The bench builds the block with its default parameters: a 5-bit code-group, a 4-bit nibble and the error nibble 1110 for a malformed start delimiter. With these values every one of the 32 code-group values has a defined meaning. The bench therefore drives all sixteen data symbols, each delimiter in the wrong position, and invalid symbols both inside and outside a frame. It also checks the one-cycle recovery after each error and a reset that arrives in the middle of a frame.

// File: rtl/rx4b5b_pkg.sv
package rx4b5b_pkg;

    localparam int CODE_W = 5;
    localparam int NIB_W  = 4;

    localparam logic [CODE_W-1:0] SYM_J    = 5'b11000;
    localparam logic [CODE_W-1:0] SYM_K    = 5'b10001;
    localparam logic [CODE_W-1:0] SYM_T    = 5'b01101;
    localparam logic [CODE_W-1:0] SYM_R    = 5'b00111;
    localparam logic [CODE_W-1:0] SYM_IDLE = 5'b11111;

    typedef enum logic [2:0] {
        K_DATA,
        K_J,
        K_K,
        K_T,
        K_R,
        K_IDLE,
        K_BAD
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        logic [NIB_W-1:0]  nib;
    } sym_t;

    typedef enum logic [1:0] {
        S_WAIT,
        S_GOTJ,
        S_FRAME,
        S_GOTT
    } st_e;

    typedef struct packed {
        logic              dv;
        logic              er;
        logic [NIB_W-1:0]  nib;
    } mii_t;

    localparam mii_t MII_QUIET = '{dv: 1'b0, er: 1'b0, nib: '0};

    function automatic sym_t classify(input logic [CODE_W-1:0] c);
        sym_t s;
        s.kind = K_DATA;
        s.nib  = '0;
        unique case (c)
            5'b11110: s.nib = 4'h0;
            5'b01001: s.nib = 4'h1;
            5'b10100: s.nib = 4'h2;
            5'b10101: s.nib = 4'h3;
            5'b01010: s.nib = 4'h4;
            5'b01011: s.nib = 4'h5;
            5'b01110: s.nib = 4'h6;
            5'b01111: s.nib = 4'h7;
            5'b10010: s.nib = 4'h8;
            5'b10011: s.nib = 4'h9;
            5'b10110: s.nib = 4'hA;
            5'b10111: s.nib = 4'hB;
            5'b11010: s.nib = 4'hC;
            5'b11011: s.nib = 4'hD;
            5'b11100: s.nib = 4'hE;
            5'b11101: s.nib = 4'hF;
            SYM_J:    s.kind = K_J;
            SYM_K:    s.kind = K_K;
            SYM_T:    s.kind = K_T;
            SYM_R:    s.kind = K_R;
            SYM_IDLE: s.kind = K_IDLE;
            default:  s.kind = K_BAD;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/rx4b5b_classify.sv
module rx4b5b_classify
    import rx4b5b_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output sym_t              sym_o
);

    always_comb begin
        sym_o = classify(code_i);
    end

endmodule

// File: rtl/rx4b5b_fsm.sv
module rx4b5b_fsm
    import rx4b5b_pkg::*;
#(
    parameter logic [NIB_W-1:0] BAD_SSD_NIB = 4'b1110
) (
    input  logic clk,
    input  logic rst,
    input  sym_t sym_i,
    output mii_t nxt_o
);

    st_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (rst) st_q <= S_WAIT;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d  = st_q;
        nxt_o = MII_QUIET;
        unique case (st_q)
            S_WAIT: begin
                if (sym_i.kind == K_J) st_d = S_GOTJ;
            end
            S_GOTJ: begin
                if (sym_i.kind == K_K) begin
                    st_d = S_FRAME;
                end else begin
                    st_d      = S_WAIT;
                    nxt_o.er  = 1'b1;
                    nxt_o.nib = BAD_SSD_NIB;
                end
            end
            S_FRAME: begin
                if (sym_i.kind == K_DATA) begin
                    nxt_o.dv  = 1'b1;
                    nxt_o.nib = sym_i.nib;
                end else if (sym_i.kind == K_T) begin
                    st_d = S_GOTT;
                end else begin
                    nxt_o.dv = 1'b1;
                    nxt_o.er = 1'b1;
                end
            end
            S_GOTT: begin
                st_d = S_WAIT;
                if (sym_i.kind != K_R) nxt_o.er = 1'b1;
            end
            default: st_d = S_WAIT;
        endcase
    end

endmodule

// File: rtl/rx4b5b_mii_reg.sv
module rx4b5b_mii_reg
    import rx4b5b_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  mii_t d_i,
    output mii_t q_o
);

    always_ff @(posedge clk) begin
        if (rst) q_o <= MII_QUIET;
        else     q_o <= d_i;
    end

endmodule

// File: rtl/rx4b5b_rx.sv
module rx4b5b_rx
    import rx4b5b_pkg::*;
#(
    parameter logic [NIB_W-1:0] BAD_SSD_NIB = 4'b1110
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_i,
    output logic              rx_dv,
    output logic [NIB_W-1:0]  rxd,
    output logic              rx_er
);

    sym_t sym;
    mii_t nxt;
    mii_t cur;

    rx4b5b_classify u_classify (
        .code_i (code_i),
        .sym_o  (sym)
    );

    rx4b5b_fsm #(
        .BAD_SSD_NIB (BAD_SSD_NIB)
    ) u_fsm (
        .clk   (clk),
        .rst   (rst),
        .sym_i (sym),
        .nxt_o (nxt)
    );

    rx4b5b_mii_reg u_out (
        .clk (clk),
        .rst (rst),
        .d_i (nxt),
        .q_o (cur)
    );

    assign rx_dv = cur.dv;
    assign rx_er = cur.er;
    assign rxd   = cur.nib;

endmodule

// File: rtl/rx4b5b_rx_chk.sv
module rx4b5b_rx_chk
    import rx4b5b_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] code_i,
    input logic              rx_dv,
    input logic [NIB_W-1:0]  rxd,
    input logic              rx_er
);

    logic [1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst)                hist_q <= 2'd0;
        else if (hist_q != 2'd3) hist_q <= hist_q + 2'd1;
    end

    // R1: the edge after reset leaves every output low
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!rx_dv && !rx_er && rxd == '0));

    // R5 and R8: an error shown with data-valid low lasts one code-group time
    p_er_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        (rx_er && !rx_dv) |=> !rx_er);

    // R3: data-valid only rises two code-groups after a K
    p_dv_after_k_r3: assert property (@(posedge clk) disable iff (rst)
        (hist_q == 2'd3 && $rose(rx_dv)) |-> $past(code_i, 2) == SYM_K);

    // R7: a T sampled on the previous edge never gives data-valid
    p_t_no_dv_r7: assert property (@(posedge clk) disable iff (rst)
        (hist_q != 2'd0 && $past(code_i) == SYM_T) |-> !rx_dv);

    // R2: while idle symbols stream in, the outputs stay low
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (hist_q == 2'd3 && $past(code_i) == SYM_IDLE && $past(code_i, 2) == SYM_IDLE
         && !$past(rx_dv)) |-> (!rx_dv && !rx_er));

endmodule

bind rx4b5b_rx rx4b5b_rx_chk i_chk (
    .clk    (clk),
    .rst    (rst),
    .code_i (code_i),
    .rx_dv  (rx_dv),
    .rxd    (rxd),
    .rx_er  (rx_er)
);

// File: tb/test_rx4b5b_rx.sv
module test_rx4b5b_rx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] code = 5'b11111;
    logic       rx_dv;
    logic [3:0] rxd;
    logic       rx_er;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    rx4b5b_rx i_rx4b5b_rx (
        .clk    (clk),
        .rst    (rst),
        .code_i (code),
        .rx_dv  (rx_dv),
        .rxd    (rxd),
        .rx_er  (rx_er)
    );

    localparam logic [4:0] C_J = 5'b11000;
    localparam logic [4:0] C_K = 5'b10001;
    localparam logic [4:0] C_T = 5'b01101;
    localparam logic [4:0] C_R = 5'b00111;
    localparam logic [4:0] C_I = 5'b11111;
    localparam logic [4:0] C_Z = 5'b00000;

    localparam logic [4:0] DATA_SYM [16] = '{
        5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011, 5'b01110, 5'b01111,
        5'b10010, 5'b10011, 5'b10110, 5'b10111, 5'b11010, 5'b11011, 5'b11100, 5'b11101
    };

    // {code, dv, rxd, er, check_rxd}
    localparam int NV = 30;
    localparam logic [11:0] VEC [NV] = '{
        {C_I,      1'b0, 4'h0, 1'b0, 1'b1},  // R2 idle
        {C_Z,      1'b0, 4'h0, 1'b0, 1'b1},  // R2 junk outside frame
        {C_T,      1'b0, 4'h0, 1'b0, 1'b1},  // R2 stray T
        {C_J,      1'b0, 4'h0, 1'b0, 1'b1},  // R3 J hidden
        {C_K,      1'b0, 4'h0, 1'b0, 1'b1},  // R3 K hidden
        {5'b01011, 1'b1, 4'h5, 1'b0, 1'b1},  // R4
        {5'b10110, 1'b1, 4'hA, 1'b0, 1'b1},  // R4
        {5'b11110, 1'b1, 4'h0, 1'b0, 1'b1},  // R4
        {5'b11101, 1'b1, 4'hF, 1'b0, 1'b1},  // R4
        {C_T,      1'b0, 4'h0, 1'b0, 1'b1},  // R7
        {C_R,      1'b0, 4'h0, 1'b0, 1'b1},  // R7
        {C_I,      1'b0, 4'h0, 1'b0, 1'b1},  // R7 back to wait
        {C_J,      1'b0, 4'h0, 1'b0, 1'b1},
        {C_I,      1'b0, 4'hE, 1'b1, 1'b1},  // R5 bad start
        {C_I,      1'b0, 4'h0, 1'b0, 1'b1},  // R5 one cycle only
        {C_J,      1'b0, 4'h0, 1'b0, 1'b1},
        {C_K,      1'b0, 4'h0, 1'b0, 1'b1},
        {5'b10101, 1'b1, 4'h3, 1'b0, 1'b1},
        {C_Z,      1'b1, 4'h0, 1'b1, 1'b0},  // R6 invalid in frame
        {5'b10011, 1'b1, 4'h9, 1'b0, 1'b1},  // R6 frame continues
        {C_T,      1'b0, 4'h0, 1'b0, 1'b1},
        {C_I,      1'b0, 4'h0, 1'b1, 1'b0},  // R8 T not R
        {5'b01001, 1'b0, 4'h0, 1'b0, 1'b1},  // R8 frame closed
        {C_J,      1'b0, 4'h0, 1'b0, 1'b1},
        {C_J,      1'b0, 4'hE, 1'b1, 1'b1},  // R5 J J
        {C_K,      1'b0, 4'h0, 1'b0, 1'b1},  // R5 second J not a start
        {C_J,      1'b0, 4'h0, 1'b0, 1'b1},
        {C_K,      1'b0, 4'h0, 1'b0, 1'b1},
        {C_T,      1'b0, 4'h0, 1'b0, 1'b1},  // R7 empty frame
        {C_R,      1'b0, 4'h0, 1'b0, 1'b1}
    };

    task automatic check(input logic edv, input logic [3:0] erxd, input logic eer,
                         input logic chk, input string tag);
        total++;
        if (rx_dv !== edv || rx_er !== eer || (chk && rxd !== erxd)) begin
            bad++;
            $display("FAIL %s: got dv=%b rxd=%h er=%b, expected dv=%b rxd=%h er=%b",
                     tag, rx_dv, rxd, rx_er, edv, erxd, eer);
        end
    endtask

    // drive one code-group, then sample the registered result after the edge (R9)
    task automatic step(input logic [4:0] c, input logic edv, input logic [3:0] erxd,
                        input logic eer, input logic chk, input string tag);
        @(negedge clk);
        code = c;
        @(posedge clk);
        #1;
        check(edv, erxd, eer, chk, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(1'b0, 4'h0, 1'b0, 1'b1, "R1 reset");
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][11:7], VEC[i][6], VEC[i][5:2], VEC[i][1], VEC[i][0],
                 $sformatf("R9 vector %0d", i));
        end

        // R4: every data symbol in one frame
        step(C_J, 1'b0, 4'h0, 1'b0, 1'b1, "R3 J");
        step(C_K, 1'b0, 4'h0, 1'b0, 1'b1, "R3 K");
        for (int n = 0; n < 16; n++) begin
            step(DATA_SYM[n], 1'b1, 4'(n), 1'b0, 1'b1, "R4 mapping");
        end
        step(C_J, 1'b1, 4'h0, 1'b1, 1'b0, "R6 J inside frame");
        step(C_I, 1'b1, 4'h0, 1'b1, 1'b0, "R6 idle inside frame");
        step(C_T, 1'b0, 4'h0, 1'b0, 1'b1, "R7 T");
        step(C_R, 1'b0, 4'h0, 1'b0, 1'b1, "R7 R");
        step(DATA_SYM[7], 1'b0, 4'h0, 1'b0, 1'b1, "R2 data outside frame");

        // R1: reset in mid-frame
        step(C_J, 1'b0, 4'h0, 1'b0, 1'b1, "R3 J");
        step(C_K, 1'b0, 4'h0, 1'b0, 1'b1, "R3 K");
        step(DATA_SYM[7], 1'b1, 4'h7, 1'b0, 1'b1, "R4 data");
        @(negedge clk);
        rst = 1'b1;
        code = DATA_SYM[7];
        @(posedge clk);
        #1;
        check(1'b0, 4'h0, 1'b0, 1'b1, "R1 reset mid-frame");
        @(negedge clk);
        rst = 1'b0;
        step(DATA_SYM[7], 1'b0, 4'h0, 1'b0, 1'b1, "R1 state cleared");
        step(C_K, 1'b0, 4'h0, 1'b0, 1'b1, "R1 K alone");
        step(DATA_SYM[2], 1'b0, 4'h0, 1'b0, 1'b1, "R1 no frame");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog: got running, expected finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule